// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

This block is a single down-counting timer channel with a parameterised width (16 bits by default). A one-cycle load strobe writes an initial count and a 3-bit operating mode. After that, the channel decrements once for each cycle in which the count-enable input is high. Its one output line follows one of six waveforms:

- terminal-count interrupt
- gate-triggered one-shot
- periodic rate pulse
- square wave
- software-started strobe
- gate-started strobe

A gate input can pause counting or restart it, depending on the mode. The live count value is available at all times for readback.

The block sits behind a host bus decoder, which is not part of it. That decoder assembles the count bytes and issues the single load strobe. Count-enable is a synchronous qualifier in the channel's clock domain. Each waveform is a pure function of the initial value N (a zero written means 2^W) and of the number of counted enables since the last load or restart.

Top module: `timer_channel`

## Requirements
- R1: While reset is high, and on the first cycle after it, `count` is 0 and `tmr_out` is low.
- R2: A load makes `count` equal to `load_val` on the next cycle. A count-enable in the same cycle as the load does not decrement. The mode written takes effect at that load.
- R3: Mode codes 6 and 7 behave exactly like codes 2 and 3. Codes 0 to 5 are taken as written.
- R4: In modes 0, 1, 4 and 5, each counted enable lowers `count` by one. The count wraps from 0 to all-ones and is never reloaded.
- R5: Mode 0: `tmr_out` goes low on the load. It goes high after N counted enables and stays high until the next load.
- R6: Mode 1: `tmr_out` is high after a load. On the cycle after a gate rising edge it goes low, and it returns high after N counted enables. A new rising edge while low reloads the count and starts a fresh full interval.
- R7: Modes 2 and 3: `count` steps N, N-1, ..., 1 and then reloads to N. Mode 2: `tmr_out` is high only from each reload until the next counted enable, so there is no pulse before the first full period.
- R8: Mode 3: `tmr_out` is high while the phase (counted enables modulo N) is below (N+1)/2, and low for the rest of each period.
- R9: Modes 4 and 5: `tmr_out` is high only between the N-th and the (N+1)-th counted enable after the load or restart. It never pulses again, even when the count wraps.
- R10: A gate rising edge reloads the count to N and restarts the waveform in modes 1, 2, 3 and 5. In modes 0 and 4, gate edges change nothing. A rising edge in the same cycle as a load is ignored.
- R11: A low gate stops decrementing in modes 0, 2, 3 and 4. Modes 1 and 5 count regardless of the gate. In modes 2 and 3, `tmr_out` is held high while the sampled gate is low.
- R12: An initial value of 0 acts as a count of 2^W in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-enable qualifier, one decrement per high cycle |
| gate | input | 1 | Gate level, sampled each clock |
| load | input | 1 | Load strobe for a new initial value and mode |
| load_val | input | CNT_W | Initial count (0 means 2^CNT_W) |
| load_mode | input | 3 | Operating mode code |
| tmr_out | output | 1 | Channel output waveform |
| count | output | CNT_W | Current count value |

## Verification
Every result passes through exactly one register stage. A load, a gate edge or a counted enable presented before a rising edge is visible on `count` and `tmr_out` after that same edge. The gate level that forces the output high in modes 2 and 3 is also the registered level from that edge. The bench therefore drives each stimulus half a cycle before the edge and advances its arithmetic model at the edge. It compares both outputs at the following falling edge, so each check lands one edge after its cause. The model derives every expected value from N and the number of counted enables, not from a decrementing register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        M_TERM    = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } tmr_mode_e;

    // Events produced by the count core each cycle
    typedef struct packed {
        logic tick;      // counted enable that actually moved the counter
        logic restart;   // gate rising edge accepted by the current mode
        logic terminal;  // tick taken while the counter held one
    } tmr_evt_t;

    // Waveform state
    typedef struct packed {
        logic armed;
        logic flag;
    } tmr_wave_t;

    // Codes 6 and 7 fold onto the periodic modes
    function automatic tmr_mode_e norm_mode(input logic [2:0] code);
        if (code[1])
            return tmr_mode_e'({1'b0, code[1:0]});
        return tmr_mode_e'(code);
    endfunction

    function automatic logic gate_pauses(input tmr_mode_e m);
        return (m == M_TERM) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTB);
    endfunction

    function automatic logic gate_restarts(input tmr_mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
    endfunction

    function automatic logic is_periodic(input tmr_mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    output logic gate_q,
    output logic gate_rise
);
    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate;
    end

    assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  tmr_mode_e        new_mode,
    input  logic             cnt_en,
    input  logic             gate,
    input  logic             gate_rise,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] init,
    output tmr_mode_e        mode,
    output tmr_evt_t         evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic en_ok;
    logic restart;
    logic tick;

    assign en_ok   = cnt_en & (gate | ~gate_pauses(mode));
    assign restart = gate_rise & gate_restarts(mode) & ~load;
    assign tick    = en_ok & ~load & ~restart;

    assign evt.tick     = tick;
    assign evt.restart  = restart;
    assign evt.terminal = tick & (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            init <= '0;
            mode <= M_TERM;
        end else if (load) begin
            cnt  <= load_val;
            init <= load_val;
            mode <= new_mode;
        end else if (restart) begin
            cnt <= init;
        end else if (tick) begin
            if (is_periodic(mode) && cnt == ONE)
                cnt <= init;
            else
                cnt <= cnt - ONE;
        end
    end

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)))
        else $error("load value not taken"); // R2

    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (tick && !is_periodic(mode)) |=> (cnt == $past(cnt) - ONE))
        else $error("one-shot mode count did not step down"); // R4

    AST_GATE_PAUSE: assert property (@(posedge clk) disable iff (rst)
        (!load && !restart && !gate && gate_pauses(mode)) |=> $stable(cnt))
        else $error("count moved with gate low"); // R11

    AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (is_periodic(mode) && init != '0) |-> (cnt != '0 && cnt <= init))
        else $error("periodic count left 1..N"); // R7
endmodule

// File: rtl/tmr_wave_gen.sv
module tmr_wave_gen
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  tmr_mode_e        new_mode,
    input  tmr_mode_e        mode,
    input  tmr_evt_t         evt,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] init,
    input  logic             gate_q,
    output logic             out
);
    localparam int EXT_W = CNT_W + 1;
    localparam logic [EXT_W-1:0] FULL = EXT_W'(1) << CNT_W;

    tmr_wave_t st;
    logic [EXT_W-1:0] cnt_ext;
    logic [EXT_W-1:0] init_ext;
    logic             sq_high;

    // A zero register value stands for the full range
    assign cnt_ext  = (cnt  == '0) ? FULL : {1'b0, cnt};
    assign init_ext = (init == '0) ? FULL : {1'b0, init};
    assign sq_high  = cnt_ext > (init_ext >> 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st.armed <= 1'b0;
            st.flag  <= 1'b0;
        end else if (load) begin
            st.armed <= (new_mode != M_ONESHOT);
            st.flag  <= 1'b0;
        end else if (evt.restart) begin
            st.armed <= 1'b1;
            st.flag  <= 1'b0;
        end else if (evt.tick) begin
            case (mode)
                M_TERM: begin
                    if (evt.terminal && st.armed) begin
                        st.flag  <= 1'b1;
                        st.armed <= 1'b0;
                    end
                end
                M_ONESHOT: begin
                    if (evt.terminal && st.armed) st.armed <= 1'b0;
                end
                M_RATE:   st.flag <= evt.terminal;
                M_SQUARE: st.flag <= 1'b0;
                default: begin
                    st.flag <= evt.terminal & st.armed;
                    if (evt.terminal) st.armed <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        case (mode)
            M_ONESHOT: out = ~st.armed;
            M_RATE:    out = ~gate_q | st.flag;
            M_SQUARE:  out = ~gate_q | sq_high;
            default:   out = st.flag;
        endcase
    end

    AST_TERM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mode == M_TERM && out && !load) |=> out)
        else $error("terminal output dropped"); // R5

    AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        ((mode == M_SWSTB || mode == M_HWSTB) && out && evt.tick) |=> !out)
        else $error("strobe lasted past one tick"); // R9

    AST_ONESHOT_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ONESHOT && evt.restart) |=> !out)
        else $error("one-shot did not go low on trigger"); // R6
endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             gate,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [2:0]       load_mode,
    output logic             tmr_out,
    output logic [CNT_W-1:0] count
);
    tmr_mode_e        new_mode;
    tmr_mode_e        mode;
    tmr_evt_t         evt;
    logic             gate_q;
    logic             gate_rise;
    logic [CNT_W-1:0] init;

    assign new_mode = norm_mode(load_mode);

    tmr_gate_edge u_gate (
        .clk       (clk),
        .rst       (rst),
        .gate      (gate),
        .gate_q    (gate_q),
        .gate_rise (gate_rise)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (load_val),
        .new_mode  (new_mode),
        .cnt_en    (cnt_en),
        .gate      (gate),
        .gate_rise (gate_rise),
        .cnt       (count),
        .init      (init),
        .mode      (mode),
        .evt       (evt)
    );

    tmr_wave_gen #(.CNT_W(CNT_W)) u_wave (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .new_mode (new_mode),
        .mode     (mode),
        .evt      (evt),
        .cnt      (count),
        .init     (init),
        .gate_q   (gate_q),
        .out      (tmr_out)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (count == '0 && !tmr_out))
        else $error("reset state wrong"); // R1
endmodule

// File: tb/sim_timer_channel.sv
module sim_timer_channel;
    localparam int W          = 4;
    localparam int MODV       = 1 << W;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en = 1'b0;
    logic         gate = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [2:0]   load_mode = '0;
    logic         tmr_out;
    logic [W-1:0] count;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Arithmetic model state
    int m_mode = 0;
    int m_n    = MODV;
    int m_d    = 0;
    bit m_trig = 1'b0;
    bit m_gq   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_channel #(.CNT_W(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .gate      (gate),
        .load      (load),
        .load_val  (load_val),
        .load_mode (load_mode),
        .tmr_out   (tmr_out),
        .count     (count)
    );

    function automatic int fold(input int code);
        return ((code & 2) != 0) ? (code & 3) : code;
    endfunction

    function automatic int exp_count();
        if (m_mode == 2 || m_mode == 3)
            return (m_n - (m_d % m_n)) % MODV;
        return (((m_n - m_d) % MODV) + MODV) % MODV;
    endfunction

    function automatic int exp_out();
        case (m_mode)
            0: return (m_d >= m_n) ? 1 : 0;
            1: return (m_trig && m_d < m_n) ? 0 : 1;
            2: return (!m_gq || (m_d != 0 && (m_d % m_n) == 0)) ? 1 : 0;
            3: return (!m_gq || (m_d % m_n) < (m_n + 1) / 2) ? 1 : 0;
            default: return (m_d == m_n) ? 1 : 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (mode=%0d n=%0d d=%0d)",
                     tag, what, act, exp, m_mode, m_n, m_d);
        end
    endtask

    task automatic model_step(input bit ld, input int lm, input int lv, input bit en, input bit g);
        bit rise;
        rise = g && !m_gq;
        if (ld) begin
            m_mode = fold(lm);
            m_n    = (lv == 0) ? MODV : lv;
            m_d    = 0;
            m_trig = 1'b0;
        end else if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
            m_d    = 0;
            m_trig = 1'b1;
        end else if (en && (g || m_mode == 1 || m_mode == 5)) begin
            m_d++;
        end
        m_gq = g;
    endtask

    task automatic cycle(input bit ld, input int lm, input int lv, input bit en, input bit g);
        string tc;
        string to;
        int    fm;
        fm = ld ? fold(lm) : m_mode;
        case (fm)
            0: begin tc = "R4"; to = "R5"; end
            1: begin tc = "R4"; to = "R6"; end
            2: begin tc = "R7"; to = "R7"; end
            3: begin tc = "R7"; to = "R8"; end
            default: begin tc = "R4"; to = "R9"; end
        endcase
        if (ld) begin tc = "R2"; to = "R2"; end
        else if (!g) begin tc = "R11"; to = "R11"; end
        else if (!m_gq) begin tc = "R10"; to = "R10"; end
        if (lm >= 6) begin tc = {tc, "/R3"}; to = {to, "/R3"}; end
        if (lv == 0) begin tc = {tc, "/R12"}; to = {to, "/R12"}; end
        load      = ld;
        load_mode = 3'(lm);
        load_val  = W'(lv);
        cnt_en    = en;
        gate      = g;
        @(posedge clk);
        model_step(ld, lm, lv, en, g);
        @(negedge clk);
        chk(tc, "count", int'(count), exp_count());
        chk(to, "out", int'(tmr_out), exp_out());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "count", int'(count), 0);
        chk("R1", "out", int'(tmr_out), 0);
        rst = 1'b0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int md = 0; md < 8; md++) begin
                for (int nv = 0; nv < MODV; nv++) begin
                    int nn;
                    int len;
                    nn  = (nv == 0) ? MODV : nv;
                    len = 2 * nn + 12;
                    // load with a count-enable in the same cycle
                    cycle(1'b1, md, nv, 1'b1, 1'b1);
                    for (int k = 1; k < len; k++) begin
                        bit en;
                        bit g;
                        en = ((k * 5 + nv) % 7) != 0;
                        g  = (pass == 0) ? 1'b1 : !((k % 13) >= 10);
                        cycle(1'b0, md, nv, en, g);
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule